// File: doc/BRIEF.md
# Stack Push/Pop/Exchange Unit

This unit carries out the stack transfers of an 8-bit processor core on 16-bit register pairs. A single command either saves a selected pair onto the stack, restores a selected pair from the stack, or swaps the HL pair with the two bytes at the top of the stack. The core hands over the current stack pointer and the four pair values with the command. The unit then runs the byte-wide memory accesses itself, in a fixed order, and returns the updated stack pointer and pair values together with a one-cycle completion strobe.

The selectable pairs are BC, DE, HL and a status word. In the status word the accumulator is the upper byte and the flags register is the lower byte. Each operation takes a fixed number of clock cycles: 12 for a push, 10 for a pop and 16 for an exchange. The memory is a synchronous single-port array, and its read data arrives one clock after the address. Stack pointer arithmetic wraps modulo 2^16.

Top module: `stack_xfer_unit`

## Requirements
- R1: Push (op 01) writes the pair's upper byte to SP-1 in the first cycle after acceptance and its lower byte to SP-2 in the second cycle. The returned stack pointer is SP-2.
- R2: Pop (op 10) reads SP in the first cycle after acceptance and SP+1 in the second. Read data arrives one clock after its address. The byte from SP becomes the pair's lower byte, the byte from SP+1 becomes its upper byte, and the returned stack pointer is SP+2.
- R3: The pair code selects 00 = BC, 01 = DE, 10 = HL and 11 = status word. The status word carries the accumulator in bits [15:8] and the flags in bits [7:0]. The exchange ignores the pair code and always works on HL.
- R4: Only the pair addressed by a pop or exchange changes; every other pair is returned as given. The flags byte (stat_out[7:0]) changes only when the status word is popped.
- R5: busy is high from the first cycle after acceptance through the completion cycle. done is a single-cycle pulse in cycle 12 (push), 10 (pop) or 16 (exchange), counted from the cycle after the accepting edge as cycle 1.
- R6: Exchange (op 11) reads SP and SP+1 in cycles 1 and 2. It writes the old L to SP in cycle 3 and the old H to SP+1 in cycle 4. HL returns as {M[SP+1], M[SP]}, and the stack pointer is returned unchanged.
- R7: All stack addresses and the returned stack pointer wrap modulo 2^16, both downward past 0000h and upward past FFFFh.
- R8: The op code is 00 = none, 01 = push, 10 = pop, 11 = exchange. A command is accepted only when cmd_valid is high, busy is low and the op is not 00. Any other command, and any change to the inputs while busy, has no effect on the bus or on the results.
- R9: From the done cycle until the next accepted command, sp_out and the four pair outputs hold their results.
- R10: While reset is active and right after it, busy, done, mem_rd and mem_wr are low and every result output is zero.
- R11: In every cycle without a memory access, mem_rd, mem_wr, mem_addr and mem_wdata are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Operation code (see R8) |
| cmd_pair | input | 2 | Pair select (see R3) |
| sp_in | input | 16 | Stack pointer before the operation |
| bc_in | input | 16 | BC pair value |
| de_in | input | 16 | DE pair value |
| hl_in | input | 16 | HL pair value |
| stat_in | input | 16 | Status word value (accumulator high, flags low) |
| mem_rdata | input | 8 | Memory read data, valid one clock after the address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| sp_out | output | 16 | Updated stack pointer |
| bc_out | output | 16 | Resulting BC pair |
| de_out | output | 16 | Resulting DE pair |
| hl_out | output | 16 | Resulting HL pair |
| stat_out | output | 16 | Resulting status word |
| mem_addr | output | 16 | Memory byte address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |

## Verification
On every cycle the assertions check the following: the hold of busy and its operation once a command is accepted; the release after done; the mutual exclusion of read and write strobes; the capture of the upper byte directly after the lower; that untargeted pairs stay unchanged while busy; and that the stack pointer result holds between acceptances. Only the bench scenarios can show the actual byte order and addresses on the bus, the exact done cycle for each operation, the values restored from memory, and the memory contents left behind. The same holds for wrap-around at both ends of the address space and for rejection of commands sent while busy or with the null op.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_SWAP = 2'b11
  } stk_op_e;

  localparam int NPAIR = 4;

  localparam logic [1:0] PAIR_BC   = 2'd0;
  localparam logic [1:0] PAIR_DE   = 2'd1;
  localparam logic [1:0] PAIR_HL   = 2'd2;
  localparam logic [1:0] PAIR_STAT = 2'd3;

endpackage

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int PUSH_LAT = 12,
  parameter int POP_LAT  = 10,
  parameter int SWAP_LAT = 16,
  parameter int CNT_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  stk_op_e          cmd_op,
  output logic             go,
  output logic             busy,
  output logic             done,
  output stk_op_e          op_q,
  output logic [CNT_W-1:0] step
);

  localparam logic [CNT_W-1:0] LAT_PUSH = CNT_W'(PUSH_LAT);
  localparam logic [CNT_W-1:0] LAT_POP  = CNT_W'(POP_LAT);
  localparam logic [CNT_W-1:0] LAT_SWAP = CNT_W'(SWAP_LAT);
  localparam logic [CNT_W-1:0] STEP_ONE = CNT_W'(1);

  stk_op_e          op_n;
  logic [CNT_W-1:0] step_n;
  logic [CNT_W-1:0] lat;

  always_comb begin
    case (op_q)
      OP_PUSH: lat = LAT_PUSH;
      OP_POP:  lat = LAT_POP;
      OP_SWAP: lat = LAT_SWAP;
      default: lat = '0;
    endcase
  end

  assign busy = (op_q != OP_NONE);
  assign done = busy && (step == lat);
  assign go   = cmd_valid && !busy && (cmd_op != OP_NONE);

  always_comb begin
    op_n   = op_q;
    step_n = step;
    if (go) begin
      op_n   = cmd_op;
      step_n = STEP_ONE;
    end else if (done) begin
      op_n   = OP_NONE;
      step_n = '0;
    end else if (busy) begin
      step_n = step + STEP_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= OP_NONE;
      step <= '0;
    end else begin
      op_q <= op_n;
      step <= step_n;
    end
  end

  assert_go_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy);

  assert_done_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && $stable(op_q)));

endmodule

// File: rtl/stk_bus.sv
module stk_bus
  import stk_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  stk_op_e             op_q,
  input  logic [CNT_W-1:0]    step,
  input  logic [ADDR_W-1:0]   base_q,
  input  logic [2*BYTE_W-1:0] src_q,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic [BYTE_W-1:0]   mem_wdata,
  output logic                cap_lo,
  output logic                cap_hi
);

  localparam int PAIR_W = 2 * BYTE_W;
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);
  localparam logic [CNT_W-1:0]  S1  = CNT_W'(1);
  localparam logic [CNT_W-1:0]  S2  = CNT_W'(2);
  localparam logic [CNT_W-1:0]  S3  = CNT_W'(3);
  localparam logic [CNT_W-1:0]  S4  = CNT_W'(4);

  logic [BYTE_W-1:0] src_hi;
  logic [BYTE_W-1:0] src_lo;

  assign src_hi = src_q[PAIR_W-1:BYTE_W];
  assign src_lo = src_q[BYTE_W-1:0];

  always_comb begin
    mem_addr  = '0;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_wdata = '0;
    cap_lo    = 1'b0;
    cap_hi    = 1'b0;
    case (op_q)
      OP_PUSH: begin
        if (step == S1) begin
          mem_addr  = base_q - ONE;
          mem_wr    = 1'b1;
          mem_wdata = src_hi;
        end else if (step == S2) begin
          mem_addr  = base_q - TWO;
          mem_wr    = 1'b1;
          mem_wdata = src_lo;
        end
      end
      OP_POP: begin
        if (step == S1) begin
          mem_addr = base_q;
          mem_rd   = 1'b1;
        end else if (step == S2) begin
          mem_addr = base_q + ONE;
          mem_rd   = 1'b1;
          cap_lo   = 1'b1;
        end else if (step == S3) begin
          cap_hi   = 1'b1;
        end
      end
      OP_SWAP: begin
        if (step == S1) begin
          mem_addr = base_q;
          mem_rd   = 1'b1;
        end else if (step == S2) begin
          mem_addr = base_q + ONE;
          mem_rd   = 1'b1;
          cap_lo   = 1'b1;
        end else if (step == S3) begin
          mem_addr  = base_q;
          mem_wr    = 1'b1;
          mem_wdata = src_lo;
          cap_hi    = 1'b1;
        end else if (step == S4) begin
          mem_addr  = base_q + ONE;
          mem_wr    = 1'b1;
          mem_wdata = src_hi;
        end
      end
      default: ;
    endcase
  end

  assert_rd_wr_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !mem_rd);

  assert_hi_after_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hi |-> $past(cap_lo));

endmodule

// File: rtl/stk_regs.sv
module stk_regs
  import stk_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic                busy,
  input  stk_op_e             cmd_op,
  input  stk_op_e             op_q,
  input  logic [1:0]          cmd_pair,
  input  logic [ADDR_W-1:0]   sp_in,
  input  logic [2*BYTE_W-1:0] bc_in,
  input  logic [2*BYTE_W-1:0] de_in,
  input  logic [2*BYTE_W-1:0] hl_in,
  input  logic [2*BYTE_W-1:0] stat_in,
  input  logic                cap_lo,
  input  logic                cap_hi,
  input  logic [BYTE_W-1:0]   rdata,
  output logic [ADDR_W-1:0]   base_q,
  output logic [ADDR_W-1:0]   sp_q,
  output logic [2*BYTE_W-1:0] src_q,
  output logic [2*BYTE_W-1:0] bc_q,
  output logic [2*BYTE_W-1:0] de_q,
  output logic [2*BYTE_W-1:0] hl_q,
  output logic [2*BYTE_W-1:0] stat_q
);

  localparam int PAIR_W = 2 * BYTE_W;
  localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

  logic [PAIR_W-1:0] in_arr [NPAIR];
  logic [PAIR_W-1:0] pr_q   [NPAIR];
  logic [PAIR_W-1:0] pr_n   [NPAIR];
  logic [1:0]        pair_q;
  logic [1:0]        pair_n;
  logic [ADDR_W-1:0] base_n;
  logic [ADDR_W-1:0] sp_n;
  logic [PAIR_W-1:0] src_n;

  always_comb begin
    in_arr[PAIR_BC]   = bc_in;
    in_arr[PAIR_DE]   = de_in;
    in_arr[PAIR_HL]   = hl_in;
    in_arr[PAIR_STAT] = stat_in;
  end

  always_comb begin
    base_n = base_q;
    sp_n   = sp_q;
    pair_n = pair_q;
    src_n  = src_q;
    pr_n   = pr_q;
    if (go) begin
      base_n = sp_in;
      case (cmd_op)
        OP_PUSH: sp_n = sp_in - TWO;
        OP_POP:  sp_n = sp_in + TWO;
        default: sp_n = sp_in;
      endcase
      pair_n = (cmd_op == OP_SWAP) ? PAIR_HL : cmd_pair;
      src_n  = in_arr[pair_n];
      pr_n   = in_arr;
    end else begin
      for (int g = 0; g < NPAIR; g++) begin
        if (pair_q == 2'(g)) begin
          if (cap_lo) pr_n[g][BYTE_W-1:0]      = rdata;
          if (cap_hi) pr_n[g][PAIR_W-1:BYTE_W] = rdata;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      sp_q   <= '0;
      pair_q <= '0;
      src_q  <= '0;
      pr_q   <= '{default: '0};
    end else begin
      base_q <= base_n;
      sp_q   <= sp_n;
      pair_q <= pair_n;
      src_q  <= src_n;
      pr_q   <= pr_n;
    end
  end

  assign bc_q   = pr_q[PAIR_BC];
  assign de_q   = pr_q[PAIR_DE];
  assign hl_q   = pr_q[PAIR_HL];
  assign stat_q = pr_q[PAIR_STAT];

  assert_sp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable(sp_q));

  assert_no_capture_push_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_lo || cap_hi) |-> (op_q != OP_PUSH));

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair_chk
    assert_untouched_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (pair_q != 2'(g))) |=> $stable(pr_q[g]));
  end

endmodule

// File: rtl/stack_xfer_unit.sv
module stack_xfer_unit
  import stk_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int BYTE_W   = 8,
  parameter int PUSH_LAT = 12,
  parameter int POP_LAT  = 10,
  parameter int SWAP_LAT = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_op,
  input  logic [1:0]          cmd_pair,
  input  logic [ADDR_W-1:0]   sp_in,
  input  logic [2*BYTE_W-1:0] bc_in,
  input  logic [2*BYTE_W-1:0] de_in,
  input  logic [2*BYTE_W-1:0] hl_in,
  input  logic [2*BYTE_W-1:0] stat_in,
  input  logic [BYTE_W-1:0]   mem_rdata,
  output logic                busy,
  output logic                done,
  output logic [ADDR_W-1:0]   sp_out,
  output logic [2*BYTE_W-1:0] bc_out,
  output logic [2*BYTE_W-1:0] de_out,
  output logic [2*BYTE_W-1:0] hl_out,
  output logic [2*BYTE_W-1:0] stat_out,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic [BYTE_W-1:0]   mem_wdata
);

  localparam int PAIR_W  = 2 * BYTE_W;
  localparam int MAX_LAT = (PUSH_LAT > POP_LAT)
                         ? ((PUSH_LAT > SWAP_LAT) ? PUSH_LAT : SWAP_LAT)
                         : ((POP_LAT > SWAP_LAT) ? POP_LAT : SWAP_LAT);
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  logic [1:0]        rst_pipe;
  logic              rst_s_n;
  logic              go;
  stk_op_e           op_q;
  stk_op_e           cmd_op_e;
  logic [CNT_W-1:0]  step;
  logic [ADDR_W-1:0] base_q;
  logic [PAIR_W-1:0] src_q;
  logic              cap_lo;
  logic              cap_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_s_n  = rst_pipe[1];
  assign cmd_op_e = stk_op_e'(cmd_op);

  stk_seq #(
    .PUSH_LAT (PUSH_LAT),
    .POP_LAT  (POP_LAT),
    .SWAP_LAT (SWAP_LAT),
    .CNT_W    (CNT_W)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op_e),
    .go        (go),
    .busy      (busy),
    .done      (done),
    .op_q      (op_q),
    .step      (step)
  );

  stk_bus #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W),
    .CNT_W  (CNT_W)
  ) bus_i (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .op_q      (op_q),
    .step      (step),
    .base_q    (base_q),
    .src_q     (src_q),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .cap_lo    (cap_lo),
    .cap_hi    (cap_hi)
  );

  stk_regs #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W)
  ) regs_i (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .go       (go),
    .busy     (busy),
    .cmd_op   (cmd_op_e),
    .op_q     (op_q),
    .cmd_pair (cmd_pair),
    .sp_in    (sp_in),
    .bc_in    (bc_in),
    .de_in    (de_in),
    .hl_in    (hl_in),
    .stat_in  (stat_in),
    .cap_lo   (cap_lo),
    .cap_hi   (cap_hi),
    .rdata    (mem_rdata),
    .base_q   (base_q),
    .sp_q     (sp_out),
    .src_q    (src_q),
    .bc_q     (bc_out),
    .de_q     (de_out),
    .hl_q     (hl_out),
    .stat_q   (stat_out)
  );

  assert_idle_bus_R11: assert property (@(posedge clk) disable iff (!rst_s_n)
    !busy |-> (!mem_rd && !mem_wr));

endmodule

// File: tb/stack_xfer_unit_tb_top.sv
module stack_xfer_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [1:0]  cmd_pair;
  logic [15:0] sp_in, bc_in, de_in, hl_in, stat_in;
  logic [7:0]  mem_rdata = 8'h00;
  logic        busy, done, mem_rd, mem_wr;
  logic [15:0] sp_out, bc_out, de_out, hl_out, stat_out, mem_addr;
  logic [7:0]  mem_wdata;

  int n_chk = 0;
  int n_err = 0;

  logic [7:0] mem [int];

  always #10 clk = ~clk;

  stack_xfer_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_pair  (cmd_pair),
    .sp_in     (sp_in),
    .bc_in     (bc_in),
    .de_in     (de_in),
    .hl_in     (hl_in),
    .stat_in   (stat_in),
    .mem_rdata (mem_rdata),
    .busy      (busy),
    .done      (done),
    .sp_out    (sp_out),
    .bc_out    (bc_out),
    .de_out    (de_out),
    .hl_out    (hl_out),
    .stat_out  (stat_out),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata)
  );

  function automatic logic [7:0] rd(input logic [15:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return 8'h00;
  endfunction

  // behavioural memory: write at the edge, read data one clock later
  always @(posedge clk) begin
    if (mem_wr) mem[int'(mem_addr)] = mem_wdata;
    if (mem_rd) mem_rdata <= rd(mem_addr);
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // reference model: expected per-cycle bus and final results, built from the requirements
  task automatic run_cmd(input logic [1:0] op, input logic [1:0] pair,
                         input logic [15:0] sp, input logic [15:0] bc,
                         input logic [15:0] de, input logic [15:0] hl,
                         input logic [15:0] st, input bit poke,
                         input string ttag);
    logic [15:0] prs [4];
    logic [15:0] ea  [1:4];
    logic        ew  [1:4];
    logic        er  [1:4];
    logic [7:0]  ed  [1:4];
    logic [15:0] v, esp, a1, am1, am2;
    logic [31:0] outs [4];
    int          lat;
    int          tgt;
    string       tg;
    for (int k = 1; k <= 4; k++) begin
      ea[k] = '0; ew[k] = 1'b0; er[k] = 1'b0; ed[k] = '0;
    end
    prs[0] = bc; prs[1] = de; prs[2] = hl; prs[3] = st;
    tgt = (op == 2'd3) ? 2 : int'(pair);
    v   = prs[tgt];
    a1  = sp + 16'd1;
    am1 = sp - 16'd1;
    am2 = sp - 16'd2;
    case (op)
      2'd1: begin
        lat = 12; tg = "R1";
        ea[1] = am1; ew[1] = 1'b1; ed[1] = v[15:8];
        ea[2] = am2; ew[2] = 1'b1; ed[2] = v[7:0];
        esp = am2;
      end
      2'd2: begin
        lat = 10; tg = "R2";
        ea[1] = sp; er[1] = 1'b1;
        ea[2] = a1; er[2] = 1'b1;
        prs[tgt] = {rd(a1), rd(sp)};
        esp = sp + 16'd2;
      end
      default: begin
        lat = 16; tg = "R6";
        ea[1] = sp; er[1] = 1'b1;
        ea[2] = a1; er[2] = 1'b1;
        ea[3] = sp; ew[3] = 1'b1; ed[3] = v[7:0];
        ea[4] = a1; ew[4] = 1'b1; ed[4] = v[15:8];
        prs[2] = {rd(a1), rd(sp)};
        esp = sp;
      end
    endcase
    if (ttag != "") tg = ttag;

    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_pair = pair;
    sp_in = sp; bc_in = bc; de_in = de; hl_in = hl; stat_in = st;

    for (int i = 1; i <= lat; i++) begin
      @(negedge clk);
      chk("R5", "busy", 32'(busy), 32'd1);
      chk("R5", "done", 32'(done), 32'(i == lat));
      if (i <= 4 && (ew[i] || er[i])) begin
        chk(tg, "mem_wr", 32'(mem_wr), 32'(ew[i]));
        chk(tg, "mem_rd", 32'(mem_rd), 32'(er[i]));
        chk(tg, "mem_addr", 32'(mem_addr), 32'(ea[i]));
        if (ew[i]) chk(tg, "mem_wdata", 32'(mem_wdata), 32'(ed[i]));
      end else begin
        chk("R11", "mem_wr idle", 32'(mem_wr), 32'd0);
        chk("R11", "mem_rd idle", 32'(mem_rd), 32'd0);
        chk("R11", "mem_addr idle", 32'(mem_addr), 32'd0);
        chk("R11", "mem_wdata idle", 32'(mem_wdata), 32'd0);
      end
      if (i == lat) begin
        outs[0] = 32'(bc_out); outs[1] = 32'(de_out);
        outs[2] = 32'(hl_out); outs[3] = 32'(stat_out);
        chk(tg, "sp_out", 32'(sp_out), 32'(esp));
        for (int k = 0; k < 4; k++) begin
          if (k == tgt && op != 2'd1) chk("R3", $sformatf("pair%0d %s", k, tg), outs[k], 32'(prs[k]));
          else chk("R4", $sformatf("pair%0d", k), outs[k], 32'(prs[k]));
        end
      end
      if (i == 1) cmd_valid = 1'b0;
      if (poke && i == 3) begin
        cmd_valid = 1'b1; cmd_op = 2'd2; cmd_pair = 2'd0;
        sp_in = 16'h1234; bc_in = ~bc; hl_in = 16'hDEAD; stat_in = 16'hBEEF;
      end
      if (poke && i == 6) cmd_valid = 1'b0;
    end

    @(negedge clk);
    chk("R5", "busy after done", 32'(busy), 32'd0);
    chk("R9", "sp_out held", 32'(sp_out), 32'(esp));
    chk("R9", "hl_out held", 32'(hl_out), 32'(prs[2]));
    if (op == 2'd1) begin
      chk(tg, "mem at SP-1", 32'(rd(am1)), 32'(v[15:8]));
      chk(tg, "mem at SP-2", 32'(rd(am2)), 32'(v[7:0]));
    end else if (op == 2'd3) begin
      chk(tg, "mem at SP", 32'(rd(sp)), 32'(v[7:0]));
      chk(tg, "mem at SP+1", 32'(rd(a1)), 32'(v[15:8]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL R5 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] sp_keep;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_pair = 2'd0;
    sp_in = '0; bc_in = '0; de_in = '0; hl_in = '0; stat_in = '0;
    repeat (3) @(negedge clk);
    chk("R10", "busy in reset", 32'(busy), 32'd0);
    chk("R10", "mem_wr in reset", 32'(mem_wr), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10", "busy", 32'(busy), 32'd0);
    chk("R10", "done", 32'(done), 32'd0);
    chk("R10", "mem_rd", 32'(mem_rd), 32'd0);
    chk("R10", "mem_wr", 32'(mem_wr), 32'd0);
    chk("R10", "sp_out", 32'(sp_out), 32'd0);
    chk("R10", "hl_out", 32'(hl_out), 32'd0);
    chk("R10", "stat_out", 32'(stat_out), 32'd0);

    // R1: push HL, 56h to 24FFh and 78h to 24FEh
    run_cmd(2'd1, 2'd2, 16'h2500, 16'h1111, 16'h2222, 16'h5678, 16'h2459, 1'b0, "");
    // R2: pop into DE from the same place
    run_cmd(2'd2, 2'd1, 16'h24FE, 16'h1111, 16'h0000, 16'h9999, 16'h2459, 1'b0, "");
    // R3: push status word, pop it into BC
    run_cmd(2'd1, 2'd3, 16'h4000, 16'h0101, 16'h0202, 16'h0303, 16'h24A5, 1'b0, "");
    run_cmd(2'd2, 2'd0, 16'h3FFE, 16'h0000, 16'h0202, 16'h0303, 16'h0100, 1'b0, "");
    // R4: popping the status word loads the flags byte
    mem[32'h5000] = 8'hC3; mem[32'h5001] = 8'h7E;
    run_cmd(2'd2, 2'd3, 16'h5000, 16'hAAAA, 16'hBBBB, 16'hCCCC, 16'h0100, 1'b0, "");
    // R6: exchange HL with top of stack, pair code ignored
    mem[32'h3000] = 8'h1A; mem[32'h3001] = 8'h2C;
    run_cmd(2'd3, 2'd0, 16'h3000, 16'h1234, 16'h5678, 16'h2102, 16'h0F0F, 1'b0, "");
    // R7: wrap at both ends
    run_cmd(2'd1, 2'd0, 16'h0001, 16'hABCD, 16'h0000, 16'h0000, 16'h0000, 1'b0, "R7");
    run_cmd(2'd2, 2'd1, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, "R7");
    run_cmd(2'd3, 2'd2, 16'hFFFF, 16'h0000, 16'h0000, 16'h3344, 16'h0000, 1'b0, "R7");
    // R8: command and input changes while busy are ignored
    run_cmd(2'd1, 2'd1, 16'h6000, 16'h0011, 16'hC0DE, 16'h0033, 16'h0044, 1'b1, "R8");

    // R8: null op is not accepted
    sp_keep = sp_out;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0; sp_in = 16'h7777;
    @(negedge clk);
    chk("R8", "busy after null op", 32'(busy), 32'd0);
    chk("R8", "mem_wr after null op", 32'(mem_wr), 32'd0);
    chk("R8", "sp_out after null op", 32'(sp_out), 32'(sp_keep));
    cmd_valid = 1'b0;

    // R9: results hold while idle
    repeat (5) @(negedge clk);
    chk("R9", "sp_out idle hold", 32'(sp_out), 32'(sp_keep));
    chk("R11", "mem_addr idle", 32'(mem_addr), 32'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule